// File: doc/BRIEF.md
# Bounded Port Address Sequencer

This block holds the read port number that a multiplexed data system steps through during each scan. A 5-bit counter moves forward one port for every scan-advance pulse. The configured number of ports in use sets a ceiling on that counter. When an end-of-scan pulse ends and the next port number would be higher than that ceiling, the counter is loaded with its present value plus two, which skips the next value.

The counter drives two outputs. One is a copy with its bits in reverse order, which goes to a RAM address selector. The other path compares the count with a 5-bit minor frame count. A registered strobe is raised when the count and the minor frame count are equal and the word number is at a fixed position (word 28 by default).

Top module: `pseq_top`

## Requirements
- R1: While rst_ni is low, port_o is 0 and match_o is 0. An arm that was pending before reset does not cause a load after reset is released.
- R2: With no load pending, a clock edge on which scan_adv_i is high sets port_o to its previous value plus one, modulo 32, so 31 is followed by 0.
- R3: With no load pending and scan_adv_i low, port_o holds its value.
- R4: port_rev_o bit i equals port_o bit (4 - i) for every i from 0 to 4, in the same cycle.
- R5: The skip is armed on the first clock edge at which eos_i is low after it was high at the previous edge. At that edge, port_o plus one (modulo 32) must be strictly greater than ports_used_i.
- R6: On the clock edge after the arming edge, port_o becomes its value at that edge plus two, modulo 32. The load overrides scan_adv_i.
- R7: No load happens when eos_i has not just fallen, or when port_o plus one is less than or equal to ports_used_i.
- R8: match_o is high for the cycle after an edge where word_i equals 28 and all five bits of port_o equal mfc_i, including the MSB. In all other cases match_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scan_adv_i | input | 1 | Advance the port counter by one |
| eos_i | input | 1 | End-of-scan pulse; its falling edge is sampled |
| ports_used_i | input | 5 | Highest port number in use |
| mfc_i | input | 5 | Minor frame count |
| word_i | input | 5 | Current word number in the frame |
| port_o | output | 5 | Current port address |
| port_rev_o | output | 5 | port_o with bit order reversed |
| match_o | output | 1 | Registered strobe: frame count equals port at word 28 |

## Verification
An increment or hold shows on port_o one edge after it is sampled. A skip load is two edges after the first low sample of eos_i: one edge to arm and one to load. match_o follows its qualifying inputs by one edge, and port_rev_o follows port_o in the same cycle. The bench drives inputs and samples outputs on the falling clock edge. Its reference model counts the same number of edges, so each directed check reads the result in the cycle that this timing gives.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int unsigned ADDR_W_DEF = 5;
  localparam int unsigned WORD_W_DEF = 5;
  localparam int unsigned MATCH_WORD_DEF = 28;
endpackage

// File: rtl/pseq_counter.sv
module pseq_counter #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              load_i,
  output logic [ADDR_W-1:0] cnt_o,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = cnt_q + TWO;  // skip the next value
    else if (adv_i) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign nxt_o = cnt_q + ONE;
endmodule

// File: rtl/pseq_skip.sv
module pseq_skip #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eos_i,
  input  logic [ADDR_W-1:0] nxt_i,
  input  logic [ADDR_W-1:0] limit_i,
  output logic              load_o
);
  logic eos_q;
  logic arm_q;
  logic over;
  logic eos_fall;

  assign over     = nxt_i > limit_i;
  assign eos_fall = eos_q & ~eos_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eos_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      eos_q <= eos_i;
      arm_q <= eos_fall & over;
    end
  end

  assign load_o = arm_q;
endmodule

// File: rtl/pseq_match.sv
module pseq_match #(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned WORD_W     = 5,
  parameter int unsigned MATCH_WORD = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cnt_i,
  input  logic [ADDR_W-1:0] mfc_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              match_o
);
  localparam logic [WORD_W-1:0] WORD_SEL = WORD_W'(MATCH_WORD);

  logic low_eq;
  logic msb_diff;
  logic hit;
  logic match_q;

  // low bits by equality, MSB by xor
  assign low_eq   = (cnt_i[ADDR_W-2:0] == mfc_i[ADDR_W-2:0]);
  assign msb_diff = cnt_i[ADDR_W-1] ^ mfc_i[ADDR_W-1];
  assign hit      = low_eq & ~msb_diff & (word_i == WORD_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= hit;
  end

  assign match_o = match_q;
endmodule

// File: rtl/pseq_top.sv
module pseq_top #(
  parameter int unsigned ADDR_W     = pseq_pkg::ADDR_W_DEF,
  parameter int unsigned WORD_W     = pseq_pkg::WORD_W_DEF,
  parameter int unsigned MATCH_WORD = pseq_pkg::MATCH_WORD_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_adv_i,
  input  logic              eos_i,
  input  logic [ADDR_W-1:0] ports_used_i,
  input  logic [ADDR_W-1:0] mfc_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [ADDR_W-1:0] port_o,
  output logic [ADDR_W-1:0] port_rev_o,
  output logic              match_o
);
  logic [ADDR_W-1:0] cnt;
  logic [ADDR_W-1:0] nxt;
  logic              load;

  pseq_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (scan_adv_i),
    .load_i (load),
    .cnt_o  (cnt),
    .nxt_o  (nxt)
  );

  pseq_skip #(.ADDR_W(ADDR_W)) u_skip (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .eos_i   (eos_i),
    .nxt_i   (nxt),
    .limit_i (ports_used_i),
    .load_o  (load)
  );

  pseq_match #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .MATCH_WORD (MATCH_WORD)
  ) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt),
    .mfc_i   (mfc_i),
    .word_i  (word_i),
    .match_o (match_o)
  );

  for (genvar i = 0; i < ADDR_W; i++) begin : g_rev
    assign port_rev_o[i] = cnt[ADDR_W-1-i];
  end

  assign port_o = cnt;
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker #(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned WORD_W     = 5,
  parameter int unsigned MATCH_WORD = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scan_adv_i,
  input logic              eos_i,
  input logic [ADDR_W-1:0] ports_used_i,
  input logic [ADDR_W-1:0] mfc_i,
  input logic [WORD_W-1:0] word_i,
  input logic [ADDR_W-1:0] port_o,
  input logic [ADDR_W-1:0] port_rev_o,
  input logic              match_o,
  input logic              load_i
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);
  localparam logic [WORD_W-1:0] WSEL = WORD_W'(MATCH_WORD);

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_state_R1: assert (port_o == '0 && !match_o);
    end
  end

  assert_incr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && scan_adv_i) |=> port_o == $past(port_o) + ONE);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !scan_adv_i) |=> $stable(port_o));

  for (genvar i = 0; i < ADDR_W; i++) begin : g_rev_chk
    assert_rev_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_rev_o[i] == port_o[ADDR_W-1-i]);
  end

  assert_arm_over_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_i) |-> ($past(port_o) + ONE) > $past(ports_used_i));

  assert_load_skip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> port_o == $past(port_o) + TWO);

  assert_load_after_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !$past(eos_i));

  assert_match_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ($past(word_i) == WSEL && $past(port_o) == $past(mfc_i)));
endmodule

bind pseq_top pseq_checker #(
  .ADDR_W     (ADDR_W),
  .WORD_W     (WORD_W),
  .MATCH_WORD (MATCH_WORD)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scan_adv_i   (scan_adv_i),
  .eos_i        (eos_i),
  .ports_used_i (ports_used_i),
  .mfc_i        (mfc_i),
  .word_i       (word_i),
  .port_o       (port_o),
  .port_rev_o   (port_rev_o),
  .match_o      (match_o),
  .load_i       (load)
);

// File: tb/pseq_top_tb.sv
module pseq_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adv = 1'b0;
  logic       eos = 1'b0;
  logic [4:0] used = 5'd31;
  logic [4:0] mfc = 5'd0;
  logic [4:0] word = 5'd0;
  logic [4:0] port;
  logic [4:0] port_rev;
  logic       match;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int m_port = 0;
  int m_eos_prev = 0;
  int m_arm = 0;
  int m_match = 0;

  always #2 clk = ~clk;

  pseq_top u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scan_adv_i   (adv),
    .eos_i        (eos),
    .ports_used_i (used),
    .mfc_i        (mfc),
    .word_i       (word),
    .port_o       (port),
    .port_rev_o   (port_rev),
    .match_o      (match)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rev5(input int v);
    int r = 0;
    for (int i = 0; i < 5; i++) if (v[i]) r |= 1 << (4 - i);
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_port = 0; m_eos_prev = 0; m_arm = 0; m_match = 0;
    end else begin
      int np;
      int na;
      if (m_arm != 0)  np = (m_port + 2) % 32;
      else if (adv)    np = (m_port + 1) % 32;
      else             np = m_port;
      na = (m_eos_prev == 1 && eos == 1'b0 && ((m_port + 1) % 32) > int'(used)) ? 1 : 0;
      m_match = (int'(word) == 28 && m_port == int'(mfc)) ? 1 : 0;
      m_eos_prev = eos ? 1 : 0;
      m_arm = na;
      m_port = np;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    chk("R2 R3 R5 R6 R7 port", int'(port), m_port);
    chk("R4 reversed", int'(port_rev), rev5(int'(port)));
    chk("R8 match", int'(match), m_match);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset with a falling eos pending
    eos = 1'b1;
    step(2);
    eos = 1'b0;
    step(1);
    chk("R1 reset port", int'(port), 0);
    chk("R1 reset match", int'(match), 0);
    rst_n = 1'b1;
    step(3);
    chk("R1 no load after reset", int'(port), 0);

    // R2: count through wrap
    used = 5'd31;
    adv = 1'b1;
    step(31);
    chk("R2 reach 31", int'(port), 31);
    step(1);
    chk("R2 wrap to 0", int'(port), 0);
    step(3);
    chk("R2 count 3", int'(port), 3);

    // R3: hold
    adv = 1'b0;
    step(5);
    chk("R3 hold", int'(port), 3);

    // R5/R6: skip when next port exceeds ports in use
    used = 5'd3;
    eos = 1'b1;
    step(1);
    eos = 1'b0;
    step(1);
    chk("R6 not yet loaded", int'(port), 3);
    step(1);
    chk("R6 skip to plus two", int'(port), 5);
    chk("R4 reversed of 5", int'(port_rev), 20);

    // R6: load wins over advance
    used = 5'd4;
    adv = 1'b1;
    eos = 1'b1;
    step(1);
    eos = 1'b0;
    step(1);
    chk("R6 advance before load", int'(port), 7);
    step(1);
    chk("R6 load overrides advance", int'(port), 9);
    adv = 1'b0;
    step(1);

    // R7: eos fall with next <= limit gives no skip
    used = 5'd20;
    eos = 1'b1;
    step(1);
    eos = 1'b0;
    step(3);
    chk("R7 no skip under limit", int'(port), 9);
    // R7: eos held high, over limit, no fall
    used = 5'd2;
    eos = 1'b1;
    step(4);
    chk("R7 no skip without fall", int'(port), 9);
    eos = 1'b0;
    step(3);
    chk("R5 skip on fall", int'(port), 11);

    // R8: match strobe
    word = 5'd28;
    mfc = 5'd11;
    step(1);
    chk("R8 match high", int'(match), 1);
    mfc = 5'd27;  // differs only in MSB
    step(1);
    chk("R8 msb mismatch", int'(match), 0);
    mfc = 5'd11;
    word = 5'd27;
    step(1);
    chk("R8 wrong word", int'(match), 0);
    word = 5'd0;

    // mixed stimulus against the model
    for (int k = 0; k < 3000; k++) begin
      adv  = 1'($urandom % 2);
      eos  = (($urandom % 4) == 0);
      used = 5'($urandom);
      mfc  = ($urandom % 2) ? port : 5'($urandom);
      word = ($urandom % 3 == 0) ? 5'd28 : 5'($urandom);
      step(1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule